// File: doc/BRIEF.md
# Converter Result Register Update Controller

This block decides when a periodically produced conversion result may be written into the result register that the host reads. A 2-bit select turns the converter on and picks its input channel. The value 00 turns the converter off. The select is applied only on the block's own conversion-period boundary. Results that arrive from the converter are held in a one-entry buffer. They move into the result register only when the host is not reading it and the update-warning flag has been high long enough.

The update-warning flag tells a polling host what to expect. While the flag is low, no register write can happen for at least a lead interval. While it is high, a write follows within a bounded time. A host read cycle blocks writes from its start until it ends. Dropping chip-select also ends it. A conversion that finishes during a read is kept in the buffer, and a newer one replaces it. All intervals are counted in time-base ticks, so simulation runs stay short.

Top module: `adc_update_ctrl`

## Requirements
- R1: After reset, `result` is 0, and `upd_pending` and `conv_en` are 0.
- R2: A change on `sel` reaches `conv_en` and `conv_ch` only on a period boundary. A boundary is the PERIOD_TICKS-th tick after reset and every PERIOD_TICKS ticks after that. `conv_en` is 1 exactly when the applied select (`conv_ch`) is not 00.
- R3: After `sel` changes from 00 to a non-zero value, the first write to `result` occurs within FIRST_TICKS ticks, given a converter that answers once per period.
- R4: Once results are flowing, each converter result is written to `result` unchanged, and successive writes are PERIOD_TICKS ticks apart.
- R5: A write to `result` happens only after `upd_pending` has been 1 for at least LEAD_TICKS ticks without a break. So while the flag reads 0, no write can follow within LEAD_TICKS ticks.
- R6: While `upd_pending` is 1 and no read is in progress, a write follows within FIRST_TICKS ticks.
- R7: A pulse on `rd_start` while `cs` is 1 starts a read. From then on, `result` holds its value until the read ends. A result that arrives during the read is buffered, and a later result replaces it.
- R8: A pulse on `rd_end` ends the read, and the latest buffered result is written within 3 clocks.
- R9: Driving `cs` to 0 aborts a read in progress and lets writes resume. A pulse on `rd_start` while `cs` is 0 starts no read.
- R10: While `sel` is 00, `upd_pending` is 0 in the same cycle, the buffer is discarded and `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Requested channel; 00 turns the converter off |
| tick | input | 1 | One-clock time-base pulse |
| conv_valid | input | 1 | One-clock pulse: converter result ready |
| conv_data | input | DATA_W | Converter result |
| cs | input | 1 | Host chip-select, active high |
| rd_start | input | 1 | Host begins reading the result register |
| rd_end | input | 1 | Host finished reading the result register |
| result | output | DATA_W | Host-readable result register |
| upd_pending | output | 1 | Update-warning flag |
| conv_en | output | 1 | Converter enable |
| conv_ch | output | 2 | Select currently applied to the converter |

## Verification
The hardest case to reach is a held read during which the buffer fills more than once and is then released. In that case the register must come out holding the newest result, not the first one that was held back. The bench keeps a read open across more than two conversion periods. It releases the read, either with `rd_end` or by dropping `cs`, two clocks after a converter pulse, so that no new conversion can arrive at the moment of release. The flag lead time is measured in ticks between the rising edge of the flag and the first changed register value, after the converter has been switched off and on again.

// File: rtl/adc_update_ctrl.sv
module adc_update_ctrl #(
  parameter int DATA_W       = 8,
  parameter int PERIOD_TICKS = 10,
  parameter int LEAD_TICKS   = 24,
  parameter int FIRST_TICKS  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              tick,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              cs,
  input  logic              rd_start,
  input  logic              rd_end,
  output logic [DATA_W-1:0] result,
  output logic              upd_pending,
  output logic              conv_en,
  output logic [1:0]        conv_ch
);
  localparam int PW = $clog2(PERIOD_TICKS);
  localparam int LW = $clog2(LEAD_TICKS + 1);
  localparam int FW = $clog2(FIRST_TICKS + 2);

  logic [PW-1:0]     phase;
  logic [1:0]        act_sel;
  logic [LW-1:0]     armed;
  logic [DATA_W-1:0] buf_q;
  logic              buf_vld, hold, wr, boundary;

  assign boundary    = tick && (phase == PW'(PERIOD_TICKS - 1));
  assign conv_ch     = act_sel;
  assign conv_en     = act_sel != 2'b00;
  assign upd_pending = conv_en && (sel != 2'b00);
  assign wr          = buf_vld && !hold && upd_pending && (armed == LW'(LEAD_TICKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      act_sel <= 2'b00;
    end else if (tick) begin
      phase <= boundary ? '0 : phase + 1'b1;
      if (boundary) act_sel <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !upd_pending)                armed <= '0;
    else if (tick && armed != LW'(LEAD_TICKS)) armed <= armed + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cs) hold <= 1'b0;
    else if (rd_start) hold <= 1'b1;
    else if (rd_end)   hold <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sel == 2'b00) begin
      buf_vld <= 1'b0;
      buf_q   <= '0;
    end else if (conv_valid) begin
      buf_vld <= 1'b1;
      buf_q   <= conv_data;
    end else if (wr) begin
      buf_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  result <= '0;
    else if (wr) result <= buf_q;
  end

  logic [LW-1:0] since_low;
  logic [FW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !upd_pending)                    since_low <= '0;
    else if (tick && since_low != LW'(LEAD_TICKS)) since_low <= since_low + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !upd_pending || hold || result != buf_q) wait_cnt <= '0;
    else if (tick && wait_cnt != FW'(FIRST_TICKS + 1))   wait_cnt <= wait_cnt + 1'b1;
  end

  assert_sel_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(conv_ch));

  assert_flag_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (result != $past(result)) |-> ($past(since_low) == LW'(LEAD_TICKS)));

  assert_flag_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= FW'(FIRST_TICKS));

  assert_read_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(result));

  assert_off_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |-> !upd_pending);

  assert_off_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |=> $stable(result));
endmodule

// File: tb/adc_update_ctrl_bench.sv
`timescale 1ns/1ps
module adc_update_ctrl_bench;
  localparam int PER = 10, LEAD = 24, FIRST = 48;

  logic clk = 0, rst_n = 0;
  logic [1:0] sel = 2'b00;
  logic tick = 0, conv_valid = 0, cs = 1, rd_start = 0, rd_end = 0;
  logic [7:0] conv_data = '0;
  logic [7:0] result;
  logic upd_pending, conv_en;
  logic [1:0] conv_ch;

  int errors = 0, checks = 0, tick_n = 0, div = 0, ccnt = 0, seq = 0;
  logic run = 0;
  logic [7:0] last_data = '0;
  logic finished = 0;

  adc_update_ctrl u_adc_update_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .tick(tick), .conv_valid(conv_valid),
    .conv_data(conv_data), .cs(cs), .rd_start(rd_start), .rd_end(rd_end),
    .result(result), .upd_pending(upd_pending), .conv_en(conv_en), .conv_ch(conv_ch));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tick = 0; conv_valid = 0;
    if (run) begin
      div = div + 1;
      if (div == 4) begin
        div = 0; tick = 1; tick_n = tick_n + 1;
        if (!conv_en) ccnt = 0;
        else begin
          ccnt = ccnt + 1;
          if (ccnt == PER) begin
            ccnt = 0; conv_valid = 1;
            conv_data = {conv_ch, 6'(seq)}; last_data = conv_data; seq = seq + 1;
          end
        end
      end else if (!conv_en) ccnt = 0;
    end
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic wait_ticks(input int n);
    int t0 = tick_n;
    while (tick_n < t0 + n) step();
  endtask

  task automatic wait_conv();
    int guard = 0;
    while (!conv_valid && guard < 400) begin step(); guard++; end
  endtask

  task automatic t_reset();
    check(result == 0, "R1 result", result, 0);
    check(!upd_pending && !conv_en, "R1 flag/enable", {upd_pending, conv_en}, 0);
  endtask

  task automatic t_enable(input logic [1:0] ch);
    int t_req, t_rise, t_wr, guard;
    logic [7:0] prev = result;
    bit bad = 0;
    t_req = tick_n; sel = ch;
    t_rise = -1; t_wr = -1; guard = 0;
    while (t_wr < 0 && guard < 2000) begin
      step(); guard++;
      if (!conv_en && upd_pending) bad = 1;
      if (t_rise < 0 && conv_en) begin
        t_rise = tick_n;
        check(tick_n % PER == 0, "R2 boundary tick", tick_n % PER, 0);
        check(conv_ch == ch, "R2 channel applied", conv_ch, ch);
      end
      if (result != prev) t_wr = tick_n;
    end
    check(!bad, "R2 flag before enable", bad, 0);
    check(t_wr >= 0 && t_wr - t_req <= FIRST, "R3 first write delay", t_wr - t_req, FIRST);
    check(t_wr - t_rise >= LEAD, "R5 flag lead", t_wr - t_rise, LEAD);
    check(result == last_data, "R3 first data", result, last_data);
  endtask

  task automatic t_refresh();
    int t_prev, guard;
    logic [7:0] prev;
    for (int k = 0; k < 3; k++) begin
      prev = result; t_prev = tick_n; guard = 0;
      while (result == prev && guard < 400) begin step(); guard++; end
      if (k > 0) check(tick_n - t_prev <= PER, "R4 refresh gap", tick_n - t_prev, PER);
      check(result == last_data, "R4 data", result, last_data);
      check(tick_n - t_prev <= FIRST, "R6 flagged write bound", tick_n - t_prev, FIRST);
    end
    sel = 2'b11;
    step();
    check(conv_ch == 2'b01 || tick_n % PER == 0, "R2 no early switch", conv_ch, 1);
    check(upd_pending, "R2 flag kept on channel change", upd_pending, 1);
    wait_ticks(PER + 1);
    check(conv_ch == 2'b11, "R2 switched at boundary", conv_ch, 3);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    bit moved = 0;
    int s0;
    wait_conv(); step(); step(); step();
    rd_start = 1; step(); rd_start = 0;
    v = result; s0 = seq;
    for (int i = 0; i < 4 * 25; i++) begin step(); if (result != v) moved = 1; end
    check(!moved, "R7 held during read", moved, 0);
    check(seq - s0 >= 2, "R7 two results buffered", seq - s0, 2);
    wait_conv(); step(); step();
    rd_end = 1; step(); rd_end = 0;
    step(); step();
    check(result == last_data, "R8 newest written on release", result, last_data);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    wait_conv(); step(); step();
    rd_start = 1; step(); rd_start = 0;
    v = result;
    wait_ticks(15);
    check(result == v, "R9 held before abort", result, v);
    wait_conv(); step(); step();
    cs = 0; step(); step(); step();
    check(result == last_data, "R9 cs drop releases", result, last_data);
    rd_start = 1; step(); rd_start = 0;
    wait_conv(); step(); step(); step();
    check(result == last_data, "R9 start ignored with cs low", result, last_data);
    cs = 1;
  endtask

  task automatic t_disable();
    logic [7:0] v;
    sel = 2'b00; #0.5;
    check(!upd_pending, "R10 flag off at once", upd_pending, 0);
    v = result;
    wait_ticks(3 * PER);
    check(result == v, "R10 register kept", result, v);
    check(!conv_en, "R10 converter off", conv_en, 0);
    t_enable(2'b10);
    check(result[7:6] == 2'b10, "R10 new channel data", result[7:6], 2);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1; step();
    run = 1;
    t_enable(2'b01);
    t_refresh();
    t_hold();
    t_abort();
    t_disable();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule